// File: doc/BRIEF.md
# Age-Gated Hint Relay Queue

This block moves execution hints from a core that runs ahead of the program to a trailing core that runs the same program and produces the architecturally correct result. Every hint kind shares one first-in first-out queue. Each record carries a kind code, an age tag, a program counter and a next program counter. The kind code says whether the record is an instruction-fetch address, a data address from a committed load or store, or a branch predictor update.

At the consumer side the block checks the record at the head of the queue. The trailing core supplies its committed-instruction count. Software sets a 16-bit slack value through a small configuration port. A head record whose age tag is no greater than the count plus the slack is sent to the matching consumer output: instruction prefetch, data prefetch, or predictor update. A record that is too far ahead stays at the head until the trailing core catches up. A flush input clears the queue in one cycle when the two cores resynchronize. When the queue is full, the block refuses further pushes.

Top module: `age_gated_hint_queue`

## Requirements
- R1: After reset the queue is empty, `pushReady` is 1, all three dispatch valids are 0 and the slack value is 0.
- R2: Records of every kind leave in exactly the order they were accepted, through one shared queue.
- R3: With DEPTH records stored, `pushReady` is 0 and a push is ignored. No stored record is overwritten and no extra record appears later.
- R4: A head record whose age tag exceeds commit count plus slack is held, and no dispatch valid is raised for it in that cycle.
- R5: Kind code 2'b00 raises `iPfValid` with `iPfAddr` = record PC. Code 2'b01 raises `dPfValid` with `dPfAddr` = record PC. Code 2'b10 raises `bpValid` with `bpPc`/`bpNextPc` = record PC/next-PC. Dispatch is combinational from the head in the cycle it is eligible, and the record is popped at that clock edge.
- R6: A head record with kind code 2'b11 is removed in one cycle without raising any dispatch valid, whatever its age.
- R7: At most one dispatch valid is high in any cycle.
- R8: While `flush` is 1, no dispatch valid is raised and a push in that cycle is discarded. After the flush edge the queue is empty.
- R9: A `cfgWrite` pulse loads `cfgSlack` into the slack register. The new value applies from the following cycle.
- R10: The sum of commit count and slack is formed one bit wider than the count, so it never wraps. A record whose age equals the sum exactly is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pushValid | input | 1 | Producer offers a record |
| pushKind | input | 2 | Kind code of the offered record |
| pushAge | input | 32 | Age tag of the offered record |
| pushPc | input | 32 | PC or data address of the offered record |
| pushNextPc | input | 32 | Next-PC of the offered record |
| pushReady | output | 1 | Queue can accept a record |
| flush | input | 1 | Empty the queue (resynchronization) |
| cfgWrite | input | 1 | Load the slack register |
| cfgSlack | input | 16 | New slack value |
| commitCount | input | 32 | Consumer committed-instruction count |
| iPfValid | output | 1 | Instruction prefetch request |
| iPfAddr | output | 32 | Instruction prefetch address |
| dPfValid | output | 1 | Data prefetch request |
| dPfAddr | output | 32 | Data prefetch address |
| bpValid | output | 1 | Predictor update request |
| bpPc | output | 32 | Branch PC for the update |
| bpNextPc | output | 32 | Branch target / next PC for the update |

## Verification
The bench fills the queue to its limit and offers one more record. A design that overwrote an entry would then drain a stray or missing address. It places a head record exactly at the count-plus-slack boundary and just beyond it. An off-by-one comparison would release the record one slack step early or late. A mixed stream that contains a reserved-kind record checks that the reserved record is dropped silently and in place, not routed or left blocking the queue. A push in the same cycle as a flush checks that the record does not survive the flush. A sum near the top of the 32-bit range catches a wrapped compare, which would hold an eligible record forever.

// File: rtl/ahq_pkg.sv
package ahq_pkg;
  localparam int AGE_W   = 32;
  localparam int PC_W    = 32;
  localparam int SLACK_W = 16;

  typedef enum logic [1:0] {
    KIND_IFETCH = 2'b00,
    KIND_DATA   = 2'b01,
    KIND_BRANCH = 2'b10,
    KIND_RSVD   = 2'b11
  } hintKind_e;

  typedef struct packed {
    hintKind_e          kind;
    logic [AGE_W-1:0]   age;
    logic [PC_W-1:0]    pc;
    logic [PC_W-1:0]    nextPc;
  } hintRec_t;

  typedef struct packed {
    logic wrEn;
    logic popEn;
    logic flushEn;
  } hintStrobes_t;
endpackage

// File: rtl/ahq_datapath.sv
module ahq_datapath
  import ahq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  hintStrobes_t     strobes,
  input  hintRec_t         wrRec,
  output hintRec_t         headRec,
  output logic [CNT_W-1:0] occupancy
);
  hintRec_t          store [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.wrEn) store[wrPtr] <= wrRec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      occupancy <= '0;
    end else if (strobes.flushEn) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      occupancy <= '0;
    end else begin
      if (strobes.wrEn)  wrPtr <= bump(wrPtr);
      if (strobes.popEn) rdPtr <= bump(rdPtr);
      case ({strobes.wrEn, strobes.popEn})
        2'b10:   occupancy <= occupancy + CNT_W'(1);
        2'b01:   occupancy <= occupancy - CNT_W'(1);
        default: occupancy <= occupancy;
      endcase
    end
  end

  assign headRec = store[rdPtr];

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= CNT_W'(DEPTH));

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flushEn |=> (occupancy == '0));
endmodule

// File: rtl/ahq_control.sv
module ahq_control
  import ahq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushValid,
  input  logic               flush,
  input  logic               cfgWrite,
  input  logic [SLACK_W-1:0] cfgSlack,
  input  logic [AGE_W-1:0]   commitCount,
  input  hintRec_t           headRec,
  input  logic [CNT_W-1:0]   occupancy,
  output hintStrobes_t       strobes,
  output logic               pushReady,
  output logic               iPfValid,
  output logic               dPfValid,
  output logic               bpValid
);
  logic [SLACK_W-1:0] slackReg;
  logic [AGE_W:0]     windowEdge;
  logic               headPresent;
  logic               inWindow;
  logic               isReserved;
  logic               sendNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         slackReg <= '0;
    else if (cfgWrite) slackReg <= cfgSlack;
  end

  always_comb begin
    windowEdge  = {1'b0, commitCount} + (AGE_W+1)'(slackReg);
    headPresent = (occupancy != '0);
    inWindow    = ({1'b0, headRec.age} <= windowEdge);
    isReserved  = (headRec.kind == KIND_RSVD);
    sendNow     = headPresent && inWindow && !isReserved && !flush;
    pushReady   = (occupancy != CNT_W'(DEPTH));
    iPfValid    = sendNow && (headRec.kind == KIND_IFETCH);
    dPfValid    = sendNow && (headRec.kind == KIND_DATA);
    bpValid     = sendNow && (headRec.kind == KIND_BRANCH);
    strobes.flushEn = flush;
    strobes.wrEn    = pushValid && pushReady && !flush;
    strobes.popEn   = headPresent && !flush && (isReserved || inWindow);
  end

  p_one_dispatch_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({iPfValid, dPfValid, bpValid}));

  p_hold_head_r4: assert property (@(posedge clk) disable iff (!rstN)
    (headPresent && !inWindow && !isReserved && !flush)
      |=> ($stable(headRec) && occupancy != '0));

  p_slack_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> (slackReg == $past(cfgSlack)));

  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !(iPfValid || dPfValid || bpValid));
endmodule

// File: rtl/age_gated_hint_queue.sv
module age_gated_hint_queue
  import ahq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushValid,
  input  logic [1:0]         pushKind,
  input  logic [AGE_W-1:0]   pushAge,
  input  logic [PC_W-1:0]    pushPc,
  input  logic [PC_W-1:0]    pushNextPc,
  output logic               pushReady,
  input  logic               flush,
  input  logic               cfgWrite,
  input  logic [SLACK_W-1:0] cfgSlack,
  input  logic [AGE_W-1:0]   commitCount,
  output logic               iPfValid,
  output logic [PC_W-1:0]    iPfAddr,
  output logic               dPfValid,
  output logic [PC_W-1:0]    dPfAddr,
  output logic               bpValid,
  output logic [PC_W-1:0]    bpPc,
  output logic [PC_W-1:0]    bpNextPc
);
  hintStrobes_t     strobes;
  hintRec_t         wrRec;
  hintRec_t         headRec;
  logic [CNT_W-1:0] occupancy;

  assign wrRec = '{kind: hintKind_e'(pushKind), age: pushAge, pc: pushPc, nextPc: pushNextPc};

  ahq_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrRec(wrRec),
    .headRec(headRec), .occupancy(occupancy)
  );

  ahq_control #(.DEPTH(DEPTH)) ctl_i (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .flush(flush),
    .cfgWrite(cfgWrite), .cfgSlack(cfgSlack), .commitCount(commitCount),
    .headRec(headRec), .occupancy(occupancy), .strobes(strobes),
    .pushReady(pushReady), .iPfValid(iPfValid), .dPfValid(dPfValid),
    .bpValid(bpValid)
  );

  assign iPfAddr  = headRec.pc;
  assign dPfAddr  = headRec.pc;
  assign bpPc     = headRec.pc;
  assign bpNextPc = headRec.nextPc;
endmodule

// File: tb/age_gated_hint_queue_tb_top.sv
module age_gated_hint_queue_tb_top;
  localparam int DEPTH = 8;

  logic        clk = 0;
  logic        rstN = 0;
  logic        pushValid = 0;
  logic [1:0]  pushKind = 0;
  logic [31:0] pushAge = 0, pushPc = 0, pushNextPc = 0;
  logic        pushReady;
  logic        flush = 0, cfgWrite = 0;
  logic [15:0] cfgSlack = 0;
  logic [31:0] commitCount = 0;
  logic        iPfValid, dPfValid, bpValid;
  logic [31:0] iPfAddr, dPfAddr, bpPc, bpNextPc;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  age_gated_hint_queue #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pushOne(logic [1:0] k, logic [31:0] a, logic [31:0] p, logic [31:0] n);
    @(negedge clk);
    pushValid = 1; pushKind = k; pushAge = a; pushPc = p; pushNextPc = n;
    @(negedge clk);
    pushValid = 0;
  endtask

  task automatic setSlack(logic [15:0] s);
    @(negedge clk);
    cfgWrite = 1; cfgSlack = s;
    @(negedge clk);
    cfgWrite = 0;
  endtask

  task automatic doFlush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  function automatic logic [2:0] valids();
    return {iPfValid, dPfValid, bpValid};
  endfunction

  task automatic testReset();
    #1;
    chk("R1 pushReady", 64'(pushReady), 1);
    chk("R1 valids", 64'(valids()), 0);
  endtask

  task automatic testOrderRouting();
    commitCount = 0; setSlack(0);
    pushOne(2'b00, 5, 32'hA000, 0);
    pushOne(2'b01, 6, 32'hB000, 0);
    pushOne(2'b10, 7, 32'hC000, 32'hC040);
    pushOne(2'b11, 8, 32'hD000, 0);
    pushOne(2'b00, 9, 32'hE000, 0);
    @(negedge clk); #1;
    chk("R4 held before commit", 64'(valids()), 0);
    commitCount = 100; #1;
    chk("R5 ifetch valid", 64'(valids()), 3'b100);
    chk("R2/R5 ifetch addr", 64'(iPfAddr), 32'hA000);
    @(negedge clk); #1;
    chk("R5 data valid", 64'(valids()), 3'b010);
    chk("R2/R5 data addr", 64'(dPfAddr), 32'hB000);
    @(negedge clk); #1;
    chk("R5 branch valid", 64'(valids()), 3'b001);
    chk("R5 branch pc", {bpPc, bpNextPc}, {32'hC000, 32'hC040});
    @(negedge clk); #1;
    chk("R6 reserved silent", 64'(valids()), 0);
    @(negedge clk); #1;
    chk("R6/R2 next after reserved", {61'(iPfAddr), valids()}, {61'(32'hE000), 3'b100});
    @(negedge clk); #1;
    chk("R2 empty after drain", 64'(valids()), 0);
  endtask

  task automatic testReservedNotGated();
    commitCount = 0;
    pushOne(2'b11, 1000, 32'h1, 0);
    pushOne(2'b01, 0, 32'h2222, 0);
    #1;
    chk("R6 reserved dropped despite age", {61'(dPfAddr), valids()}, {61'(32'h2222), 3'b010});
    @(negedge clk);
  endtask

  task automatic testAgeWindow();
    commitCount = 10; setSlack(0);
    pushOne(2'b00, 12, 32'h5500, 0);
    for (int i = 0; i < 3; i++) begin
      #1; chk("R4 held beyond window", 64'(valids()), 0);
      @(negedge clk);
    end
    cfgWrite = 1; cfgSlack = 1; #1;
    chk("R9 slack not yet applied", 64'(valids()), 0);
    @(negedge clk); cfgWrite = 0; #1;
    chk("R4 still one past edge", 64'(valids()), 0);
    setSlack(2); #1;
    chk("R10/R9 equal age eligible", {61'(iPfAddr), valids()}, {61'(32'h5500), 3'b100});
    @(negedge clk); #1;
    chk("R4 popped once", 64'(valids()), 0);
  endtask

  task automatic testFull();
    int seen;
    commitCount = 0; setSlack(0);
    for (int i = 0; i < DEPTH; i++) pushOne(2'b00, 50, 32'h100 + i, 0);
    #1; chk("R3 full blocks", 64'(pushReady), 0);
    pushOne(2'b00, 50, 32'hDEAD, 0);
    #1; chk("R3 still full", 64'(pushReady), 0);
    commitCount = 60;
    seen = 0;
    for (int i = 0; i < DEPTH + 3; i++) begin
      #1;
      if (iPfValid) begin
        chk("R3/R2 drain order", 64'(iPfAddr), 64'(32'h100 + seen));
        seen++;
      end
      @(negedge clk);
    end
    chk("R3 drained count", 64'(seen), 64'(DEPTH));
    chk("R3 ready after drain", 64'(pushReady), 1);
  endtask

  task automatic testFlush();
    commitCount = 0; setSlack(0);
    pushOne(2'b00, 9, 32'h11, 0);
    pushOne(2'b01, 9, 32'h22, 0);
    @(negedge clk);
    flush = 1; commitCount = 100;
    pushValid = 1; pushKind = 2'b10; pushAge = 1; pushPc = 32'h33; #1;
    chk("R8 no dispatch in flush", 64'(valids()), 0);
    @(negedge clk);
    flush = 0; pushValid = 0; #1;
    chk("R8 empty after flush", 64'(valids()), 0);
    chk("R8 ready after flush", 64'(pushReady), 1);
    @(negedge clk); #1;
    chk("R8 flush-cycle push discarded", 64'(valids()), 0);
  endtask

  task automatic testNoWrap();
    commitCount = 32'hFFFF_FFF0; setSlack(16'hFFFF);
    pushOne(2'b10, 32'hFFFF_FFFF, 32'h7777, 32'h8888); #1;
    chk("R10 no wraparound", {61'(bpPc), valids()}, {61'(32'h7777), 3'b001});
    @(negedge clk); #1;
    chk("R7 single dispatch", 64'($countones(valids()) <= 1), 1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    rstN = 1;
    testOrderRouting();
    testReservedNotGated();
    testAgeWindow();
    testFull();
    testFlush();
    testNoWrap();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule